// File: doc/BRIEF.md
# Manchester data clock recovery

This block watches a demodulated serial line that is sampled once per clock cycle. It measures the number of cycles between line transitions and compares each interval with a programmable window for one half-bit period T. It also compares it with a 2T window that it derives from the T limits. Once the line has passed a programmable number of in-window intervals, the block waits for a 2T interval, which is the start bit. It then lock on and emits one data-clock pulse per bit, together with the recovered data bit.

An interval that fits neither window counts as a timing error. So does a line that stays quiet until the interval counter saturates, and so does a 2T interval that begins half-way through a bit. Any of these stops the clock at once and returns the block to bit checking. The same phase rules serve both codings. In Manchester mode the pulse follows the mid-bit transition and the data bit is the line level after it. In Bi-phase mode the pulse follows the bit-boundary transition and the data bit tells whether a mid-bit transition occurred.

The line input is taken on every clock cycle and cannot be stalled. The block therefore has no valid/ready pair and applies no back-pressure. The consumer must take each data bit while `rx_clk` is high. The limits, the bit-check code, the forced-on control, the coding select and the pulse width are plain levels. They should change only while no pulse is being issued.

Top module: `mdc_recover`

## Requirements
- R1: After reset, `rx_clk`, `rx_locked` and `rx_data` are all 0.
- R2: The 2T window is inclusive. Let S = t_lo + t_hi and D = t_hi - t_lo. The lower bound is S - floor(D/2) and the upper bound is S + ceil(D/2); both are the exact bounds rounded up. With t_lo = 7 and t_hi = 12 this gives 17 to 22.
- R3: An interval is a T interval when t_lo <= interval <= t_hi. An interval counts N cycles when the line level first appears N cycles after the previous transition.
- R4: No pulse is issued and `rx_locked` stays 0 until a 2T interval has ended while the block is searching for the start bit. That start-bit transition sets `rx_locked` but issues no pulse.
- R5: Each pulse relates to the line transition that causes it. `rx_clk` goes high DELAY clock edges after the edge that first samples the new line level. It stays high for `pulse_w` cycles, and a value of 0 counts as 1.
- R6: While locked, the block tracks a phase that is either the clock point or the half point. At the clock point, a T interval moves the phase to the half point with no pulse, and a 2T interval issues a pulse and keeps the phase at the clock point. At the half point, a T interval issues a pulse and returns the phase to the clock point.
- R7: A 2T interval that ends at the half point is a code violation. It clears `rx_locked`, cuts any pulse in progress and returns the block to bit checking.
- R8: While locked, an interval that fits neither window clears `rx_locked` and returns the block to bit checking. While bit checking, such an interval restarts the count of valid intervals.
- R9: `chk_sel` codes 0, 1, 2 and 3 require 0, 3, 6 or 9 consecutive in-window intervals (T or 2T) before the start-bit search begins.
- R10: When `force_on` is 1 or `chk_sel` is 0, bit checking is skipped: after any error the block searches for the start bit directly.
- R11: The data bit is loaded before its pulse and holds through it. In Manchester mode (`biphase` = 0) it is the line level after the clocking transition. In Bi-phase mode (`biphase` = 1) it is 1 when the bit ended through a T interval from the half point, and 0 when it ended through a 2T interval.
- R12: If no transition arrives for 2^CW - 1 cycles, the interval counter saturates, and this counts as a timing error that clears `rx_locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Demodulated serial line, sampled every cycle |
| t_lo | input | CW | Lower limit of the half-bit period, in cycles |
| t_hi | input | CW | Upper limit of the half-bit period, in cycles |
| chk_sel | input | 2 | Bit-check length code (0, 3, 6, 9 intervals) |
| force_on | input | 1 | Skip bit checking |
| biphase | input | 1 | 1 selects Bi-phase coding, 0 selects Manchester |
| pulse_w | input | PWW | Data-clock pulse width in cycles |
| rx_data | output | 1 | Recovered data bit |
| rx_clk | output | 1 | Recovered data clock |
| rx_locked | output | 1 | Start bit found and clock running |

## Verification
The bench builds the block with CW = 8, DELAY = 2 and PWW = 3. A counter of 8 bits saturates after 255 quiet cycles, so a single 300-cycle gap reaches the timeout. Directed limits of 7 and 12 have an odd difference, which exercises the round-up at both 2T bounds, 17 and 22, and at their rejected neighbours 16 and 23. The random configurations vary the limits, the pulse width from 1 to 4, every bit-check code, the forced-on control and both codings, so that violations, gap errors and long errors all occur inside running streams.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [1:0] {
    ST_CHECK = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2
  } mdc_state_e;

  typedef enum logic [1:0] {
    IV_BAD = 2'd0,
    IV_ONE = 2'd1,
    IV_TWO = 2'd2
  } iv_class_e;
endpackage

// File: rtl/mdc_edge_timer.sv
module mdc_edge_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  output logic          edge_o,
  output logic          level_o,
  output logic [CW-1:0] ival,
  output logic          tout
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          d_q, d_qq;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q  <= 1'b0;
      d_qq <= 1'b0;
      cnt  <= CMAX;
    end else begin
      d_q  <= din;
      d_qq <= d_q;
      if (edge_o)          cnt <= {{(CW-1){1'b0}}, 1'b1};
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end
  end

  assign edge_o  = d_q ^ d_qq;
  assign level_o = d_q;
  assign ival    = cnt;
  assign tout    = !edge_o && (cnt == CMAX - 1'b1);

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !edge_o) |=> (cnt == CMAX)); // R12
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (cnt == 1 || edge_o)); // R3
endmodule

// File: rtl/mdc_window.sv
module mdc_window
  import mdc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] lim_min,
  input  logic [CW-1:0] lim_max,
  input  logic [CW-1:0] ival,
  output iv_class_e     cls
);
  logic [CW:0] sum, dif, lo2, hi2, iv;

  always_comb begin
    sum = {1'b0, lim_min} + {1'b0, lim_max};
    dif = {1'b0, lim_max} - {1'b0, lim_min};
    lo2 = sum - (dif >> 1);
    hi2 = sum + ((dif + 1'b1) >> 1);
    iv  = {1'b0, ival};
    if (ival >= lim_min && ival <= lim_max) cls = IV_ONE;
    else if (iv >= lo2 && iv <= hi2)        cls = IV_TWO;
    else                                    cls = IV_BAD;
  end

  AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_min <= lim_max) |-> (lo2 <= hi2 && lo2 > {1'b0, lim_max})); // R2
endmodule

// File: rtl/mdc_ctrl.sv
module mdc_ctrl
  import mdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      edge_i,
  input  logic      level_i,
  input  logic      tout_i,
  input  iv_class_e cls_i,
  input  logic [1:0] chk_sel,
  input  logic      bypass,
  input  logic      biphase,
  output logic      fire,
  output logic      abort,
  output logic      locked,
  output logic      data_o
);
  mdc_state_e state;
  logic       ph;
  logic [3:0] ccnt;
  logic [3:0] need;
  logic       err_ev;

  always_comb begin
    need   = {2'b00, chk_sel} + {1'b0, chk_sel, 1'b0};
    err_ev = tout_i || (edge_i && cls_i == IV_BAD) ||
             (edge_i && state == ST_RUN && cls_i == IV_TWO && ph);
    fire   = edge_i && state == ST_RUN && !err_ev &&
             ((cls_i == IV_TWO && !ph) || (cls_i == IV_ONE && ph));
    abort  = err_ev && state == ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_CHECK;
      ph     <= 1'b0;
      ccnt   <= '0;
      data_o <= 1'b0;
    end else begin
      case (state)
        ST_CHECK: begin
          if (bypass) begin
            state <= ST_START;
            ccnt  <= '0;
          end else if (err_ev) begin
            ccnt <= '0;
          end else if (edge_i) begin
            if (ccnt + 1'b1 >= need) begin
              state <= ST_START;
              ccnt  <= '0;
            end else begin
              ccnt <= ccnt + 1'b1;
            end
          end
        end
        ST_START: begin
          if (err_ev) begin
            state <= ST_CHECK;
            ccnt  <= '0;
          end else if (edge_i && cls_i == IV_TWO) begin
            state <= ST_RUN;
            ph    <= 1'b0;
          end
        end
        default: begin
          if (err_ev) begin
            state <= ST_CHECK;
            ccnt  <= '0;
          end else if (edge_i && cls_i == IV_ONE) begin
            ph <= ~ph;
          end
        end
      endcase
      if (fire) data_o <= biphase ? (cls_i == IV_ONE) : level_i;
    end
  end

  assign locked = (state == ST_RUN);

  AST_LOCK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_i && cls_i == IV_TWO)); // R4
  AST_VIOL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && edge_i && cls_i == IV_TWO && ph) |=> !locked); // R7
  AST_BAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && cls_i == IV_BAD) |=> !locked); // R8
  AST_TOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tout_i |=> !locked); // R12
endmodule

// File: rtl/mdc_pulse.sv
module mdc_pulse #(
  parameter int DELAY = 2,
  parameter int PWW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           abort,
  input  logic [PWW-1:0] pulse_w,
  output logic           pulse
);
  localparam int TW = $clog2(DELAY + (1 << PWW) + 1);
  localparam logic [TW-1:0] DLY = TW'(DELAY);

  logic          act;
  logic [TW-1:0] tmr;
  logic [TW-1:0] last;

  assign last = DLY + ((pulse_w == '0) ? TW'(1) : TW'(pulse_w)) - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      tmr <= '0;
    end else if (abort) begin
      act <= 1'b0;
    end else if (fire) begin
      act <= 1'b1;
      tmr <= TW'(1);
    end else if (act) begin
      if (tmr == last) act <= 1'b0;
      else             tmr <= tmr + 1'b1;
    end
  end

  assign pulse = act && (tmr >= DLY);

  AST_PULSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !pulse); // R7
  AST_PULSE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pulse); // R5
endmodule

// File: rtl/mdc_recover.sv
module mdc_recover
  import mdc_pkg::*;
#(
  parameter int CW    = 8,
  parameter int DELAY = 2,
  parameter int PWW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_in,
  input  logic [CW-1:0]  t_lo,
  input  logic [CW-1:0]  t_hi,
  input  logic [1:0]     chk_sel,
  input  logic           force_on,
  input  logic           biphase,
  input  logic [PWW-1:0] pulse_w,
  output logic           rx_data,
  output logic           rx_clk,
  output logic           rx_locked
);
  logic          seen, level, tout, fire, abort;
  logic [CW-1:0] ival;
  iv_class_e     cls;

  mdc_edge_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .din(rx_in),
    .edge_o(seen), .level_o(level), .ival(ival), .tout(tout)
  );

  mdc_window #(.CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .lim_min(t_lo), .lim_max(t_hi),
    .ival(ival), .cls(cls)
  );

  mdc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .edge_i(seen), .level_i(level),
    .tout_i(tout), .cls_i(cls), .chk_sel(chk_sel),
    .bypass(force_on || chk_sel == 2'd0), .biphase(biphase),
    .fire(fire), .abort(abort), .locked(rx_locked), .data_o(rx_data)
  );

  mdc_pulse #(.DELAY(DELAY), .PWW(PWW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .abort(abort),
    .pulse_w(pulse_w), .pulse(rx_clk)
  );

  AST_CLK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk |-> rx_locked); // R4
endmodule

// File: tb/mdc_recover_test.sv
`timescale 1ns/1ps
module mdc_recover_test;
  localparam int CW = 8, DLY = 2, PWW = 3;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b0;
  logic [CW-1:0] t_lo = 8'd7, t_hi = 8'd12;
  logic [1:0] chk_sel = 2'd1;
  logic force_on = 1'b0, biphase = 1'b0;
  logic [PWW-1:0] pulse_w = 3'd2;
  logic rx_data, rx_clk, rx_locked;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_state = 0, m_cc = 0, prev = 255;
  bit m_ph = 0, exp_fire = 0, exp_data = 0;

  always #2.5 clk = ~clk;

  mdc_recover #(.CW(CW), .DELAY(DLY), .PWW(PWW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .t_lo(t_lo), .t_hi(t_hi),
    .chk_sel(chk_sel), .force_on(force_on), .biphase(biphase),
    .pulse_w(pulse_w), .rx_data(rx_data), .rx_clk(rx_clk),
    .rx_locked(rx_locked)
  );

  function automatic int lo2();
    return (int'(t_lo) + int'(t_hi)) - (int'(t_hi) - int'(t_lo)) / 2;
  endfunction
  function automatic int hi2();
    return (int'(t_lo) + int'(t_hi)) + (int'(t_hi) - int'(t_lo) + 1) / 2;
  endfunction
  function automatic int cls(int n);
    int v = (n > 255) ? 255 : n;
    if (v >= int'(t_lo) && v <= int'(t_hi)) return 1;
    if (v >= lo2() && v <= hi2()) return 2;
    return 0;
  endfunction
  function automatic int need();
    return (force_on || chk_sel == 0) ? 0 : 3 * int'(chk_sel);
  endfunction

  task automatic model(int n, bit lvl);
    int c = cls(n);
    exp_fire = 0;
    if (m_state == 0 && need() == 0) m_state = 1;
    case (m_state)
      0: begin
        if (c != 0) begin
          if (m_cc + 1 >= need()) begin m_state = 1; m_cc = 0; end
          else m_cc++;
        end else m_cc = 0;
      end
      1: begin
        if (c == 0) begin m_state = 0; m_cc = 0; end
        else if (c == 2) begin m_state = 2; m_ph = 0; end
      end
      default: begin
        if (c == 0 || (c == 2 && m_ph)) begin m_state = 0; m_cc = 0; end
        else if (c == 1) begin
          if (m_ph) begin exp_fire = 1; exp_data = biphase ? 1'b1 : lvl; end
          m_ph = !m_ph;
        end else begin
          exp_fire = 1; exp_data = biphase ? 1'b0 : lvl;
        end
      end
    endcase
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic seg(int n, string tag);
    int hits = 0, first = 0, dat = 0, pwe;
    rx_in = ~rx_in;
    model(prev, rx_in);
    prev = n;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (rx_clk) begin
        hits++;
        if (first == 0) begin first = j; dat = int'(rx_data); end
      end
    end
    if (n >= 255) begin m_state = 0; m_cc = 0; end
    pwe = (pulse_w == 0) ? 1 : int'(pulse_w);
    if (exp_fire) begin
      check(hits == pwe && first == DLY + 1, "R5", "pulse width*100+start",
            hits * 100 + first, pwe * 100 + DLY + 1);
      check(dat == int'(exp_data), "R11", "data bit", dat, int'(exp_data));
    end else begin
      check(hits == 0, tag, "pulse count", hits, 0);
    end
    check(rx_locked == (m_state == 2), tag, "locked", int'(rx_locked),
          int'(m_state == 2));
  endtask

  initial begin
    int r, n;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(rx_clk == 1'b0, "R1", "reset clk", int'(rx_clk), 0);
    check(rx_locked == 1'b0, "R1", "reset locked", int'(rx_locked), 0);
    check(rx_data == 1'b0, "R1", "reset data", int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 three valid intervals, then R2 lower neighbour 16 rejected
    repeat (4) seg(10, "R9");
    seg(16, "R2");
    seg(10, "R2");
    // R3 limits 7 accepted, R4 start bit at 17
    repeat (3) seg(7, "R3");
    seg(17, "R4");
    seg(12, "R2");
    seg(12, "R6");
    seg(22, "R6");
    seg(10, "R2");
    seg(10, "R6");
    seg(20, "R6");
    seg(10, "R6");
    seg(20, "R7");
    seg(10, "R7");
    seg(10, "R7");
    // R10 forced on
    force_on = 1'b1;
    seg(10, "R10");
    seg(20, "R10");
    seg(10, "R10");
    seg(23, "R8");
    seg(10, "R8");
    seg(20, "R10");
    seg(10, "R10");
    seg(300, "R12");
    seg(13, "R3");
    seg(6, "R3");
    force_on = 1'b0;
    chk_sel = 2'd3;
    repeat (8) seg(10, "R9");
    seg(20, "R9");
    seg(10, "R9");
    repeat (3) seg(10, "R9");
    seg(20, "R9");
    seg(10, "R9");

    for (int cfg = 0; cfg < 8; cfg++) begin
      biphase  = cfg[0];
      chk_sel  = 2'($urandom % 4);
      force_on = (cfg == 5);
      pulse_w  = 3'(1 + $urandom % 4);
      t_lo     = 8'(6 + $urandom % 4);
      t_hi     = t_lo + 8'(2 + $urandom % 5);
      for (int k = 0; k < 300; k++) begin
        r = $urandom % 100;
        if (r < 45)      n = int'(t_lo) + $urandom % (int'(t_hi) - int'(t_lo) + 1);
        else if (r < 85) n = lo2() + $urandom % (hi2() - lo2() + 1);
        else if (r < 93) n = int'(t_hi) + 1 + $urandom % (lo2() - int'(t_hi) - 1);
        else             n = hi2() + 1 + $urandom % 6;
        seg(n, "R6");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule